// File: doc/BRIEF.md
# Backward-Branch Loop Profiler

This block watches the stream of instruction fetch addresses that a processor places on its memory bus and works out which program loops run most often. It has no bus outputs: it takes a copy of each fetch and never stalls or changes a transfer. A loop shows up as a taken backward branch. A fetch whose address is below the address of the fetch before it is such a branch. The earlier address is the branch source and the new address is the loop head.

Each branch event goes to a small fully associative table of counters, keyed by the branch source. A hit increments that entry's count. A miss allocates a free entry, or replaces the entry with the lowest count when none is free. When a count would reach the top of its range, every count is halved in the same cycle, so the ranking between loops is kept. A query port returns a snapshot of the entry with the highest count.

Two small state machines control the block. The detector has states `DET_EMPTY` and `DET_TRACK`:
- Reset or clear puts it in `DET_EMPTY`.
- The first valid fetch moves it to `DET_TRACK`.
- Clear moves it back to `DET_EMPTY`.

The query port has states `QRY_IDLE` and `QRY_REPLY`:
- A request moves it to `QRY_REPLY`.
- It returns to `QRY_IDLE` when no request is present.

Top module: `loop_profiler`

## Requirements
- R1: A cycle with `fetch_valid` high is a branch event when its `fetch_addr` is strictly less than the address of the last fetch recorded with `fetch_valid` high. The event's source is that earlier address and its head is the current address.
- R2: The following produce no branch event: a fetch at an equal or higher address, and any cycle with `fetch_valid` low. A cycle with `fetch_valid` low does not change the recorded previous address.
- R3: The first valid fetch after reset or clear is never a branch event.
- R4: An event whose source matches a valid entry increments that entry's count by one and replaces its stored head with the event's head.
- R5: An event that misses while a free entry exists fills the lowest-numbered free entry with the source and head, and sets its count to 1.
- R6: An event that misses with all `ENTRIES` entries valid replaces the entry with the lowest count, taking the lowest-numbered one on a tie, and sets its count to 1.
- R7: When an increment would make a count equal 2^CNT_W-1, every count is shifted right by one bit in that cycle. The incremented value is shifted as well.
- R8: `qry_req` high at a rising edge makes `rsp_valid` high in the following cycle, and `rsp_valid` is low in any cycle after an edge without a request. The response carries `rsp_found` (any entry valid) and the source and head of the highest-count valid entry, taking the lowest-numbered one on a tie. The response reflects the table as it stood before that edge.
- R9: A high `clr` at an edge invalidates every entry and returns the detector to its initial state. A fetch presented in the same cycle as `clr` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| clr | input | 1 | Synchronous clear of the table and detector |
| fetch_valid | input | 1 | A fetch address is on the bus this cycle |
| fetch_addr | input | ADDR_W | Observed instruction fetch address |
| qry_req | input | 1 | Request a snapshot of the hottest loop |
| rsp_valid | output | 1 | Response present, one cycle after a request |
| rsp_found | output | 1 | At least one entry was valid at the snapshot |
| rsp_branch | output | ADDR_W | Branch source address of the hottest entry |
| rsp_head | output | ADDR_W | Loop-head address of the hottest entry |

## Verification
The properties assume that `clr`, `fetch_valid` and `qry_req` are known 0/1 values on every edge after reset. They also assume that a fetch address is held steady for the whole cycle in which it is flagged valid. The bench drives all inputs on the falling edge and holds them for a full period, so each value is stable when the rising edge samples it. The bench keeps every loop head below every branch source. As a result, each source-then-head pair of fetches produces exactly one branch event and no other. This makes the expected counts exact.

// File: rtl/lp_pkg.sv
`timescale 1ns/1ps
package lp_pkg;

    typedef enum logic {
        DET_EMPTY,
        DET_TRACK
    } det_state_t;

    typedef enum logic {
        QRY_IDLE,
        QRY_REPLY
    } qry_state_t;

endpackage

// File: rtl/lp_branch_detect.sv
`timescale 1ns/1ps
module lp_branch_detect
    import lp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              br_evt,
    output logic [ADDR_W-1:0] br_src,
    output logic [ADDR_W-1:0] br_head
);

    det_state_t        st_q, st_d;
    logic [ADDR_W-1:0] last_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= DET_EMPTY;
            last_q <= '0;
        end else begin
            st_q <= st_d;
            if (fetch_valid && !clr) begin
                last_q <= fetch_addr;
            end
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DET_EMPTY: if (fetch_valid && !clr) st_d = DET_TRACK;
            DET_TRACK: if (clr)                 st_d = DET_EMPTY;
            default:                            st_d = DET_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        br_src  = last_q;
        br_head = fetch_addr;
        unique case (st_q)
            DET_EMPTY: br_evt = 1'b0;
            DET_TRACK: br_evt = fetch_valid && !clr && (fetch_addr < last_q);
            default:   br_evt = 1'b0;
        endcase
    end

endmodule

// File: rtl/lp_counter_table.sv
`timescale 1ns/1ps
module lp_counter_table #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16,
    parameter int CNT_W   = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clr,
    input  logic                            br_evt,
    input  logic [ADDR_W-1:0]               br_src,
    input  logic [ADDR_W-1:0]               br_head,
    output logic [ENTRIES-1:0]              ent_valid,
    output logic [ENTRIES-1:0][ADDR_W-1:0]  ent_src,
    output logic [ENTRIES-1:0][ADDR_W-1:0]  ent_head,
    output logic [ENTRIES-1:0][CNT_W-1:0]   ent_cnt
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             hit_any, free_any, sat;
    logic [IDX_W-1:0] hit_idx, free_idx, vic_idx, put_idx;
    logic [CNT_W-1:0] vic_cnt, bump;

    always_comb begin
        hit_any  = 1'b0;
        hit_idx  = '0;
        free_any = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (ent_valid[i] && ent_src[i] == br_src) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (!ent_valid[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        vic_idx = '0;
        vic_cnt = ent_cnt[0];
        for (int i = 1; i < ENTRIES; i++) begin
            if (ent_cnt[i] < vic_cnt) begin
                vic_cnt = ent_cnt[i];
                vic_idx = IDX_W'(i);
            end
        end
        put_idx = free_any ? free_idx : vic_idx;
        bump    = ent_cnt[hit_idx] + CNT_ONE;
        sat     = hit_any && (bump == CNT_TOP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_src   <= '0;
            ent_head  <= '0;
            ent_cnt   <= '0;
        end else if (clr) begin
            ent_valid <= '0;
        end else if (br_evt) begin
            if (hit_any) begin
                ent_head[hit_idx] <= br_head;
                if (sat) begin
                    for (int i = 0; i < ENTRIES; i++) begin
                        ent_cnt[i] <= ent_cnt[i] >> 1;
                    end
                    ent_cnt[hit_idx] <= bump >> 1;
                end else begin
                    ent_cnt[hit_idx] <= bump;
                end
            end else begin
                ent_valid[put_idx] <= 1'b1;
                ent_src[put_idx]   <= br_src;
                ent_head[put_idx]  <= br_head;
                ent_cnt[put_idx]   <= CNT_ONE;
            end
        end
    end

endmodule

// File: rtl/lp_peak_select.sv
`timescale 1ns/1ps
module lp_peak_select #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16,
    parameter int CNT_W   = 16
) (
    input  logic [ENTRIES-1:0]              ent_valid,
    input  logic [ENTRIES-1:0][ADDR_W-1:0]  ent_src,
    input  logic [ENTRIES-1:0][ADDR_W-1:0]  ent_head,
    input  logic [ENTRIES-1:0][CNT_W-1:0]   ent_cnt,
    output logic                            top_found,
    output logic [ADDR_W-1:0]               top_src,
    output logic [ADDR_W-1:0]               top_head
);

    logic [CNT_W-1:0] top_cnt;

    always_comb begin
        top_found = 1'b0;
        top_src   = '0;
        top_head  = '0;
        top_cnt   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (ent_valid[i] && (!top_found || ent_cnt[i] > top_cnt)) begin
                top_found = 1'b1;
                top_src   = ent_src[i];
                top_head  = ent_head[i];
                top_cnt   = ent_cnt[i];
            end
        end
    end

endmodule

// File: rtl/loop_profiler.sv
`timescale 1ns/1ps
module loop_profiler
    import lp_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16,
    parameter int CNT_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              qry_req,
    output logic              rsp_valid,
    output logic              rsp_found,
    output logic [ADDR_W-1:0] rsp_branch,
    output logic [ADDR_W-1:0] rsp_head
);

    logic                           br_evt;
    logic [ADDR_W-1:0]              br_src, br_head;
    logic [ENTRIES-1:0]             ent_valid;
    logic [ENTRIES-1:0][ADDR_W-1:0] ent_src, ent_head;
    logic [ENTRIES-1:0][CNT_W-1:0]  ent_cnt;
    logic                           top_found;
    logic [ADDR_W-1:0]              top_src, top_head;
    qry_state_t                     q_st, q_nx;

    lp_branch_detect #(.ADDR_W(ADDR_W)) u_detect (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .br_evt(br_evt), .br_src(br_src), .br_head(br_head)
    );

    lp_counter_table #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_table (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .br_evt(br_evt), .br_src(br_src), .br_head(br_head),
        .ent_valid(ent_valid), .ent_src(ent_src),
        .ent_head(ent_head), .ent_cnt(ent_cnt)
    );

    lp_peak_select #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_peak (
        .ent_valid(ent_valid), .ent_src(ent_src),
        .ent_head(ent_head), .ent_cnt(ent_cnt),
        .top_found(top_found), .top_src(top_src), .top_head(top_head)
    );

    // query state register
    always_ff @(posedge clk) begin
        if (!rst_n) q_st <= QRY_IDLE;
        else        q_st <= q_nx;
    end

    always_comb begin
        unique case (q_st)
            QRY_IDLE:  q_nx = qry_req ? QRY_REPLY : QRY_IDLE;
            QRY_REPLY: q_nx = qry_req ? QRY_REPLY : QRY_IDLE;
            default:   q_nx = QRY_IDLE;
        endcase
    end

    // query outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_found  <= 1'b0;
            rsp_branch <= '0;
            rsp_head   <= '0;
        end else if (qry_req) begin
            rsp_found  <= top_found;
            rsp_branch <= top_src;
            rsp_head   <= top_head;
        end
    end

    assign rsp_valid = (q_st == QRY_REPLY);

endmodule

// File: rtl/lp_checker.sv
`timescale 1ns/1ps
module lp_checker #(
    parameter int ENTRIES = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clr,
    input logic               fetch_valid,
    input logic               qry_req,
    input logic               rsp_valid,
    input logic               br_evt,
    input logic [ENTRIES-1:0] ent_valid
);

    // R8
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qry_req |=> rsp_valid);

    // R8
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !qry_req |=> !rsp_valid);

    // R9
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ent_valid == '0));

    // R3
    first_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !br_evt);

    // R2
    evt_needs_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_evt |-> (fetch_valid && !clr));

    // R5
    fill_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ($countones(ent_valid) >= $countones($past(ent_valid))));

    // R6
    fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(ent_valid) <= $countones($past(ent_valid)) + 1));

endmodule

bind loop_profiler lp_checker #(.ENTRIES(ENTRIES)) u_lp_checker (
    .clk(clk), .rst_n(rst_n), .clr(clr), .fetch_valid(fetch_valid),
    .qry_req(qry_req), .rsp_valid(rsp_valid), .br_evt(br_evt),
    .ent_valid(ent_valid)
);

// File: tb/loop_profiler_test.sv
`timescale 1ns/1ps
module loop_profiler_test;

    localparam int AW = 32;
    localparam int NE = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          fetch_valid = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic          qry_req = 1'b0;
    logic          rsp_valid, rsp_found;
    logic [AW-1:0] rsp_branch, rsp_head;

    int  total = 0;
    int  bad = 0;
    bit  done = 0;

    always #10 clk = ~clk;

    loop_profiler #(.ADDR_W(AW), .ENTRIES(NE), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .qry_req(qry_req), .rsp_valid(rsp_valid), .rsp_found(rsp_found),
        .rsp_branch(rsp_branch), .rsp_head(rsp_head)
    );

    task automatic check(input bit ok, input string tag, input logic [AW-1:0] act,
                         input logic [AW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic fetch(input logic [AW-1:0] a);
        fetch_valid = 1'b1;
        fetch_addr  = a;
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    task automatic branch(input logic [AW-1:0] src, input logic [AW-1:0] head, input int n);
        for (int k = 0; k < n; k++) begin
            fetch(src);
            fetch(head);
        end
    endtask

    task automatic do_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic expect_top(input string tag, input bit found,
                              input logic [AW-1:0] src, input logic [AW-1:0] head);
        check(rsp_valid == 1'b0, {tag, " idle before query"}, AW'(rsp_valid), '0);
        qry_req = 1'b1;
        @(negedge clk);
        qry_req = 1'b0;
        check(rsp_valid == 1'b1, {tag, " R8 valid"}, AW'(rsp_valid), 1);
        check(rsp_found == found, {tag, " found"}, AW'(rsp_found), AW'(found));
        if (found) begin
            check(rsp_branch == src, {tag, " branch"}, rsp_branch, src);
            check(rsp_head == head, {tag, " head"}, rsp_head, head);
        end
        @(negedge clk);
        check(rsp_valid == 1'b0, {tag, " R8 one cycle"}, AW'(rsp_valid), '0);
    endtask

    task automatic t_reset();
        expect_top("reset", 1'b0, '0, '0);
    endtask

    task automatic t_basic();
        do_clear();
        branch(32'h8010, 32'h1000, 3);
        expect_top("R1 R5 single loop", 1'b1, 32'h8010, 32'h1000);
        branch(32'h8010, 32'h1004, 1);
        expect_top("R4 head update", 1'b1, 32'h8010, 32'h1004);
    endtask

    task automatic t_rank();
        do_clear();
        branch(32'h8100, 32'h1100, 3);
        branch(32'h8200, 32'h1200, 3);
        expect_top("R8 tie lowest", 1'b1, 32'h8100, 32'h1100);
        branch(32'h8200, 32'h1200, 1);
        expect_top("R4 R8 rank", 1'b1, 32'h8200, 32'h1200);
    endtask

    task automatic t_ignore();
        do_clear();
        fetch(32'h0100);
        fetch(32'h0200);
        fetch(32'h0200);
        fetch(32'h8000);
        fetch_addr = 32'h0010;
        @(negedge clk);
        fetch(32'h8100);
        expect_top("R2 forward equal idle", 1'b0, '0, '0);
        fetch(32'h9000);
        do_clear();
        fetch(32'h1000);
        expect_top("R3 first after clear", 1'b0, '0, '0);
    endtask

    task automatic t_clear();
        do_clear();
        branch(32'h8300, 32'h1300, 2);
        expect_top("R9 before clear", 1'b1, 32'h8300, 32'h1300);
        fetch(32'h8000);
        clr = 1'b1;
        fetch_valid = 1'b1;
        fetch_addr = 32'h1000;
        @(negedge clk);
        clr = 1'b0;
        fetch_valid = 1'b0;
        fetch(32'h0800);
        expect_top("R9 clear wins", 1'b0, '0, '0);
    endtask

    task automatic t_evict();
        do_clear();
        branch(32'h8000, 32'h1000, 20);
        for (int i = 1; i < NE; i++) begin
            branch(32'h8000 + AW'(i * 16), 32'h1000 + AW'(i * 16), i + 2);
        end
        expect_top("R5 full table", 1'b1, 32'h8000, 32'h1000);
        branch(32'h8F00, 32'h1F00, 20);
        expect_top("R6 replace tie", 1'b1, 32'h8000, 32'h1000);
        branch(32'h8F00, 32'h1F00, 1);
        expect_top("R6 replace count", 1'b1, 32'h8F00, 32'h1F00);
    endtask

    task automatic t_saturate();
        do_clear();
        branch(32'h8400, 32'h1400, 254);
        branch(32'h8500, 32'h1500, 200);
        expect_top("R7 before", 1'b1, 32'h8400, 32'h1400);
        branch(32'h8400, 32'h1400, 1);
        branch(32'h8500, 32'h1500, 27);
        expect_top("R7 halved tie", 1'b1, 32'h8400, 32'h1400);
        branch(32'h8500, 32'h1500, 1);
        expect_top("R7 halved rank", 1'b1, 32'h8500, 32'h1500);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_rank();
        t_ignore();
        t_clear();
        t_evict();
        t_saturate();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule